// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block watches 23 asynchronous input lines and turns their edges into interrupt requests and event pulses. Each line passes through a two-flop synchronizer and an edge detector. Software decides, per line, whether a rising edge, a falling edge or both set the line's pending flag. Software can also raise a line by hand through a trigger register. The pending flags stay set until software clears them.

Software reaches six 32-bit registers over a simple word bus. The bus has a request strobe, a write enable, a byte address and write data. Read data is combinational and follows the address. The interrupt request outputs are level signals. Each one is the pending flag gated by the line's interrupt mask. The event outputs are one-cycle pulses, gated by the event mask.

Top module: `ext_irq_ctrl`

## Requirements
- R1: Lines occupy bits 22:0 of every register. Bits 31:23 always read 0, and writes to them are ignored.
- R2: The registers sit at these word-aligned byte offsets:
  - 0x00: interrupt mask
  - 0x04: event mask
  - 0x08: rising select
  - 0x0C: falling select
  - 0x10: software trigger
  - 0x14: pending
  
  Offsets 0x18 and 0x1C, and any address with bits 1:0 not zero, read 0 and ignore writes. Read data follows the address in the same cycle.
- R3: After reset every register reads 0, and irq_o and evt_o are 0.
- R4: A selected edge on a line sets its pending bit. The bit reads 1 after the third rising clock edge that follows the input change. Nothing else sets it except a software trigger.
- R5: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged.
- R6: irq_o[i] equals pending[i] AND interrupt-mask[i].
- R7: evt_o[i] is high for exactly one cycle, in the cycle after a selected edge or a software trigger on line i. It fires only if the event mask bit was 1 when the edge or trigger was taken.
- R8: A line reacts to rising edges when its rising-select bit is 1 and to falling edges when its falling-select bit is 1. With both bits set, it reacts to both edges.
- R9: Writing 1 to a software trigger bit that reads 0 sets that bit and the line's pending bit, and fires the event pulse if the line is enabled. Writing 1 to a trigger bit that already reads 1 does nothing.
- R10: Writing 1 to a pending bit also clears the line's software trigger bit.
- R11: A write to the rising-select or falling-select register clears the pending bit of every line whose select bit changes value. Lines whose select bit keeps its value keep their pending bit.
- R12: If a set (edge or trigger) and a clear (write-1 or select change) hit a line in the same cycle, the pending bit ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 23 | Asynchronous external lines |
| bus_req_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | Write enable, valid with bus_req_i |
| bus_addr_i | input | 5 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| irq_o | output | 23 | Per-line interrupt request level |
| evt_o | output | 23 | Per-line event pulse |

## Verification
The bench uses the default parameters: 23 lines, a two-stage synchronizer and a 32-bit data word. This puts line 22 right next to the reserved field, so the top line and the ignored bits 31:23 are both exercised. The three-cycle edge latency is short enough that the bench can time a clear write to land in the exact cycle an edge is taken. A behavioural model follows the line history with a queue and is compared with irq_o, evt_o and the read data on every clock. Directed reads cover the clear, trigger and reprogramming corner cases.

// File: rtl/eic_pkg.sv
package eic_pkg;
  localparam int unsigned ADDR_W   = 5;
  localparam int unsigned WORD_LSB = 2;

  typedef enum logic [2:0] {
    SEL_IMASK  = 3'd0,
    SEL_EMASK  = 3'd1,
    SEL_RISE   = 3'd2,
    SEL_FALL   = 3'd3,
    SEL_SWTRIG = 3'd4,
    SEL_PEND   = 3'd5,
    SEL_RSV6   = 3'd6,
    SEL_RSV7   = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
  parameter int unsigned W      = 23,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/eic_edge_det.sv
module eic_edge_det #(
  parameter int unsigned W = 23
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] level_i,
  input  logic [W-1:0] rise_en_i,
  input  logic [W-1:0] fall_en_i,
  output logic [W-1:0] hit_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= level_i;
  end

  assign rise  = level_i & ~prev_q;
  assign fall  = ~level_i & prev_q;
  assign hit_o = (rise & rise_en_i) | (fall & fall_en_i);
endmodule

// File: rtl/eic_cfg_regs.sv
module eic_cfg_regs
  import eic_pkg::*;
#(
  parameter int unsigned W = 23
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  reg_sel_e     wr_sel_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] imask_o,
  output logic [W-1:0] emask_o,
  output logic [W-1:0] rise_en_o,
  output logic [W-1:0] fall_en_o,
  output logic [W-1:0] sens_chg_o
);
  logic [W-1:0] imask_q, emask_q, rise_q, fall_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      imask_q <= '0;
      emask_q <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
    end else if (wr_en_i) begin
      case (wr_sel_i)
        SEL_IMASK: imask_q <= wdata_i;
        SEL_EMASK: emask_q <= wdata_i;
        SEL_RISE:  rise_q  <= wdata_i;
        SEL_FALL:  fall_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  // lines whose sensitivity is being reprogrammed this cycle
  always_comb begin
    sens_chg_o = '0;
    if (wr_en_i) begin
      if (wr_sel_i == SEL_RISE) sens_chg_o = wdata_i ^ rise_q;
      if (wr_sel_i == SEL_FALL) sens_chg_o = wdata_i ^ fall_q;
    end
  end

  assign imask_o   = imask_q;
  assign emask_o   = emask_q;
  assign rise_en_o = rise_q;
  assign fall_en_o = fall_q;
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import eic_pkg::*;
#(
  parameter int unsigned NUM_LINES   = 23,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] line_i,
  input  logic                 bus_req_i,
  input  logic                 bus_we_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [DATA_W-1:0]    bus_wdata_i,
  output logic [DATA_W-1:0]    bus_rdata_o,
  output logic [NUM_LINES-1:0] irq_o,
  output logic [NUM_LINES-1:0] evt_o
);
  localparam int unsigned N = NUM_LINES;

  reg_sel_e     sel;
  logic         aligned, wr_en;
  logic [N-1:0] wd;
  logic         unused_wdata;

  logic [N-1:0] line_sync, edge_hit;
  logic [N-1:0] imask, emask, rise_en, fall_en, sens_chg;
  logic [N-1:0] sw_set, pend_clr, pend_set;
  logic [N-1:0] pend_q, sw_q, evt_q;
  logic [N-1:0] rd_val;

  assign sel          = reg_sel_e'(bus_addr_i[ADDR_W-1:WORD_LSB]);
  assign aligned      = (bus_addr_i[WORD_LSB-1:0] == '0);
  assign wr_en        = bus_req_i & bus_we_i & aligned;
  assign wd           = bus_wdata_i[N-1:0];
  assign unused_wdata = ^bus_wdata_i[DATA_W-1:N];

  eic_sync #(.W(N), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(line_i),
    .sync_o (line_sync)
  );

  eic_cfg_regs #(.W(N)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_sel_i  (sel),
    .wdata_i   (wd),
    .imask_o   (imask),
    .emask_o   (emask),
    .rise_en_o (rise_en),
    .fall_en_o (fall_en),
    .sens_chg_o(sens_chg)
  );

  eic_edge_det #(.W(N)) u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .level_i  (line_sync),
    .rise_en_i(rise_en),
    .fall_en_i(fall_en),
    .hit_o    (edge_hit)
  );

  // software trigger only acts on bits currently at 0
  assign sw_set   = (wr_en && sel == SEL_SWTRIG) ? (wd & ~sw_q) : '0;
  assign pend_clr = ((wr_en && sel == SEL_PEND) ? wd : '0) | sens_chg;
  assign pend_set = edge_hit | sw_set;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      sw_q   <= '0;
      evt_q  <= '0;
    end else begin
      pend_q <= (pend_q & ~pend_clr) | pend_set;   // set wins
      sw_q   <= (sw_q & ~((wr_en && sel == SEL_PEND) ? wd : '0)) | sw_set;
      evt_q  <= pend_set & emask;
    end
  end

  always_comb begin
    rd_val = '0;
    if (aligned) begin
      case (sel)
        SEL_IMASK:  rd_val = imask;
        SEL_EMASK:  rd_val = emask;
        SEL_RISE:   rd_val = rise_en;
        SEL_FALL:   rd_val = fall_en;
        SEL_SWTRIG: rd_val = sw_q;
        SEL_PEND:   rd_val = pend_q;
        default:    rd_val = '0;
      endcase
    end
    bus_rdata_o        = '0;
    bus_rdata_o[N-1:0] = rd_val;
  end

  assign irq_o = pend_q & imask;
  assign evt_o = evt_q;
endmodule

// File: rtl/eic_checker.sv
module eic_checker
  import eic_pkg::*;
#(
  parameter int unsigned N      = 23,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_req_i,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [N-1:0]      bus_wd_i,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic [N-1:0]      evt_o,
  input logic [N-1:0]      pend_i,
  input logic [N-1:0]      sw_i,
  input logic [N-1:0]      emask_i,
  input logic [N-1:0]      set_i
);
  logic wr_ok, wr_pend, wr_sw;
  assign wr_ok   = bus_req_i & bus_we_i & (bus_addr_i[WORD_LSB-1:0] == '0);
  assign wr_pend = wr_ok & (bus_addr_i[ADDR_W-1:WORD_LSB] == SEL_PEND);
  assign wr_sw   = wr_ok & (bus_addr_i[ADDR_W-1:WORD_LSB] == SEL_SWTRIG);

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rdata_o[DATA_W-1:N] == '0); // R1
  AST_PEND_ONLY_BY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ##1 ((pend_i & ~$past(pend_i) & ~$past(set_i)) == '0)); // R4
  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pend |=> ((pend_i & $past(bus_wd_i) & ~$past(set_i)) == '0)); // R5
  AST_EVT_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ##1 ((evt_o & ~$past(emask_i)) == '0)); // R7
  AST_SW_FROM_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ##1 ((sw_i & ~$past(sw_i) & ~($past(wr_sw) ? $past(bus_wd_i) : '0)) == '0)); // R9
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ##1 (($past(set_i) & ~pend_i) == '0)); // R12
endmodule

bind ext_irq_ctrl eic_checker #(.N(NUM_LINES), .DATA_W(DATA_W)) u_eic_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_req_i  (bus_req_i),
  .bus_we_i   (bus_we_i),
  .bus_addr_i (bus_addr_i),
  .bus_wd_i   (bus_wdata_i[NUM_LINES-1:0]),
  .bus_rdata_o(bus_rdata_o),
  .evt_o      (evt_o),
  .pend_i     (pend_q),
  .sw_i       (sw_q),
  .emask_i    (emask),
  .set_i      (pend_set)
);

// File: tb/ext_irq_ctrl_bench.sv
module ext_irq_ctrl_bench;
  localparam int N = 23;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  lines = '0;
  logic          req = 1'b0, we = 1'b0;
  logic [4:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [N-1:0]  irq, evt;

  int n_checks = 0, n_fail = 0;
  int evt2_cnt = 0, evt4_cnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ext_irq_ctrl u_ext_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .line_i(lines),
    .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq), .evt_o(evt)
  );

  // behavioural reference model
  logic [N-1:0] m_im, m_em, m_rs, m_fs, m_sw, m_pend, m_evt;
  logic [N-1:0] hist[$];

  function automatic logic [31:0] m_read(input logic [4:0] a);
    logic [N-1:0] v;
    v = '0;
    if (a[1:0] == 2'b00) begin
      case (a[4:2])
        3'd0: v = m_im;
        3'd1: v = m_em;
        3'd2: v = m_rs;
        3'd3: v = m_fs;
        3'd4: v = m_sw;
        3'd5: v = m_pend;
        default: v = '0;
      endcase
    end
    return {9'd0, v};
  endfunction

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    logic [N-1:0] s, p, hit, wd, sws, clr, chg;
    logic wr;
    if (!rst_n) begin
      m_im = '0; m_em = '0; m_rs = '0; m_fs = '0;
      m_sw = '0; m_pend = '0; m_evt = '0;
      hist = '{'0, '0, '0};
    end else begin
      s   = hist[hist.size()-2];
      p   = hist[hist.size()-3];
      hit = (s & ~p & m_rs) | (~s & p & m_fs);
      wr  = req && we && addr[1:0] == 2'b00;
      wd  = wdata[N-1:0];
      sws = (wr && addr[4:2] == 3'd4) ? (wd & ~m_sw) : '0;
      clr = (wr && addr[4:2] == 3'd5) ? wd : '0;
      chg = '0;
      if (wr && addr[4:2] == 3'd2) chg = wd ^ m_rs;
      if (wr && addr[4:2] == 3'd3) chg = wd ^ m_fs;
      m_pend = (m_pend & ~clr & ~chg) | hit | sws;
      m_sw   = (m_sw & ~clr) | sws;
      m_evt  = (hit | sws) & m_em;
      if (wr) begin
        case (addr[4:2])
          3'd0: m_im = wd;
          3'd1: m_em = wd;
          3'd2: m_rs = wd;
          3'd3: m_fs = wd;
          default: ;
        endcase
      end
      hist.push_back(lines);
      if (hist.size() > 4) void'(hist.pop_front());
    end
    #1;
    if (rst_n) begin
      check("R6 irq model", {9'd0, irq}, {9'd0, m_pend & m_im});
      check("R7 evt model", {9'd0, evt}, {9'd0, m_evt});
      check("R2 rdata model", rdata, m_read(addr));
      if (evt[2]) evt2_cnt++;
      if (evt[4]) evt4_cnt++;
    end
  end

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic bus_rd(input logic [4:0] a, input string rq, input logic [31:0] exp);
    @(negedge clk);
    req = 1; we = 0; addr = a;
    #1 check(rq, rdata, exp);
    @(negedge clk);
    req = 0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    rst_n = 1;
    // R3 reset values
    for (int r = 0; r < 6; r++) bus_rd(5'(r * 4), "R3 reset value", 32'h0);
    check("R3 irq after reset", {9'd0, irq}, 32'h0);
    check("R3 evt after reset", {9'd0, evt}, 32'h0);
    // R1 reserved bits
    bus_wr(5'h00, 32'hFFFF_FFFF);
    bus_rd(5'h00, "R1 reserved bits", 32'h007F_FFFF);
    bus_wr(5'h00, 32'h0000_0001);
    // R2 unmapped / unaligned
    bus_wr(5'h18, 32'hFFFF_FFFF);
    bus_rd(5'h18, "R2 unmapped read", 32'h0);
    bus_wr(5'h05, 32'h0000_00FF);
    bus_rd(5'h04, "R2 unaligned write ignored", 32'h0);
    bus_rd(5'h01, "R2 unaligned read", 32'h0);
    // R4/R8 rising edge on line 0 and top line 22
    bus_wr(5'h08, 32'h0040_0001);
    @(negedge clk); lines[0] = 1; lines[22] = 1;
    wait_cyc(4);
    bus_rd(5'h14, "R4 rising edge sets pend", 32'h0040_0001);
    check("R6 irq masked", {9'd0, irq}, 32'h1);
    // R5 write 0 no effect, write 1 clears
    bus_wr(5'h14, 32'h0);
    bus_rd(5'h14, "R5 write zero ignored", 32'h0040_0001);
    bus_wr(5'h14, 32'h0040_0001);
    bus_rd(5'h14, "R5 write one clears", 32'h0);
    check("R6 irq dropped", {9'd0, irq}, 32'h0);
    // R8 falling-only on line 1, rising ignored
    bus_wr(5'h0C, 32'h0000_0002);
    @(negedge clk); lines[1] = 1;
    wait_cyc(5);
    bus_rd(5'h14, "R8 rising ignored on falling line", 32'h0);
    @(negedge clk); lines[1] = 0;
    wait_cyc(4);
    bus_rd(5'h14, "R8 falling edge sets pend", 32'h0000_0002);
    bus_wr(5'h14, 32'h0000_0002);
    // R7/R8 both edges on line 2 with event mask
    bus_wr(5'h04, 32'h0000_0014);
    bus_wr(5'h08, 32'h0040_0005);
    bus_wr(5'h0C, 32'h0000_0006);
    @(negedge clk); lines[2] = 1;
    wait_cyc(6);
    check("R7 one event on rise", evt2_cnt, 1);
    @(negedge clk); lines[2] = 0;
    wait_cyc(6);
    check("R8 both edges give two events", evt2_cnt, 2);
    bus_rd(5'h14, "R8 both edges pend", 32'h0000_0004);
    bus_wr(5'h14, 32'h0000_0004);
    // R9 software trigger on line 4
    bus_wr(5'h10, 32'h0000_0010);
    wait_cyc(2);
    check("R9 sw trigger event", evt4_cnt, 1);
    bus_rd(5'h10, "R9 sw bit set", 32'h0000_0010);
    bus_rd(5'h14, "R9 sw sets pend", 32'h0000_0010);
    bus_wr(5'h10, 32'h0000_0010);
    wait_cyc(2);
    check("R9 repeat write no event", evt4_cnt, 1);
    // R10 clearing pend clears sw bit
    bus_wr(5'h14, 32'h0000_0010);
    bus_rd(5'h10, "R10 sw bit cleared", 32'h0);
    bus_rd(5'h14, "R10 pend cleared", 32'h0);
    // R11 sensitivity change clears pend
    @(negedge clk); lines[0] = 0;
    wait_cyc(4);
    @(negedge clk); lines[0] = 1;
    wait_cyc(4);
    bus_rd(5'h14, "R11 setup pend", 32'h0000_0001);
    bus_wr(5'h08, 32'h0040_0005);
    bus_rd(5'h14, "R11 same select keeps pend", 32'h0000_0001);
    bus_wr(5'h08, 32'h0040_0004);
    bus_rd(5'h14, "R11 changed select clears pend", 32'h0);
    // R12 edge and clear in same cycle
    bus_wr(5'h08, 32'h0040_0005);
    @(negedge clk); lines[0] = 0;
    wait_cyc(4);
    bus_wr(5'h14, 32'h0000_0001);
    @(negedge clk); lines[0] = 1;
    wait_cyc(4);
    bus_rd(5'h14, "R12 setup pend", 32'h0000_0001);
    @(negedge clk); lines[0] = 0;
    wait_cyc(4);
    @(negedge clk); lines[0] = 1;
    @(negedge clk);
    bus_wr(5'h14, 32'h0000_0001);
    bus_rd(5'h14, "R12 set wins over clear", 32'h0000_0001);
    wait_cyc(3);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule